// File: doc/BRIEF.md
# SDRAM Auto-Refresh Sequencer

This block paces and issues auto-refresh cycles for a synchronous DRAM. A prescaler divides the system clock by one of seven ratios. Each divided tick advances a refresh counter. When the counter reaches a programmed compare value it clears and raises a refresh request. The request runs a fixed command train on the active-low row-strobe, column-strobe and write-enable pins:

- precharge-all;
- a programmable precharge interval;
- zero to three optional wait cycles;
- the auto-refresh command;
- three recovery cycles of no-operation.

While the train runs, a busy output stalls every other external bus access. Software sets up the block through a small write port. It loads the counter and compare value first. Writing a nonzero clock select then starts counting. A request that arrives while a train is still running is held and served as soon as that train ends.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While the clock-select field is zero the prescaler and refresh counter hold, and no command other than NOP appears on the pins.
- R2: Clock-select values 1 to 7 divide the system clock by 2, 8, 32, 128, 512, 2048 and 4096. The first tick comes that many cycles after the edge that writes the select.
- R3: Write address map: 0 = refresh counter, 1 = compare value, 2 = clock select (data bits 2:0), 3 = precharge field (bits 1:0), 4 = wait field (bits 1:0). Each write takes effect at the edge on which it is sampled. A preloaded counter value V with compare C gives a first match after C-V+1 ticks.
- R4: On a tick with counter equal to compare, the counter clears to zero and a request is raised. Precharge-all appears on the pins in the cycle after the edge following the matching tick edge. Later matches follow every C+1 ticks.
- R5: Precharge-all lasts one cycle with row strobe low, column strobe high, write enable low and the precharge-select address bit high. It is followed by precharge-field+1 NOP cycles.
- R6: After the precharge interval, wait-field (0 to 3) extra NOP cycles precede the auto-refresh command (row strobe low, column strobe low, write enable high). Exactly three NOP cycles follow that command.
- R7: A request raised while a train is running is held. The next precharge-all follows the last recovery cycle directly. Several requests raised during one train merge into one.
- R8: Busy is high for exactly the 6 + precharge-field + wait-field cycles of a train and low otherwise. Outside a train the pins carry NOP and the precharge-select bit is low.
- R9: The clock-enable pin is high from reset onward, including throughout every train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_pre_all | output | 1 | Precharge-select address bit |
| ext_bus_busy | output | 1 | Stalls other external accesses during a refresh train |

## Verification
The bench builds the block with its default 16-bit counter and 12-bit prescaler. That is the smallest prescaler that still reaches the divide-by-4096 select, so the full select sweep runs with these values. Small compare values at divide-by-2 make requests arrive faster than a long train completes. This drives the hold-and-merge path repeatedly and gives back-to-back trains with no idle cycle between them. A preloaded nonzero counter value covers the shortened first interval.

// File: rtl/rfsh_pkg.sv
// Package: shared register addresses, sequencer states and the
// clock-select to divide-shift mapping for the refresh sequencer.
package rfsh_pkg;

    localparam logic [2:0] RA_COUNT   = 3'd0;
    localparam logic [2:0] RA_COMPARE = 3'd1;
    localparam logic [2:0] RA_CLKSEL  = 3'd2;
    localparam logic [2:0] RA_PRECHG  = 3'd3;
    localparam logic [2:0] RA_WAITS   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_RP,
        ST_WAIT,
        ST_REF,
        ST_RR,
        ST_RC1,
        ST_RC2
    } rfsh_state_e;

    // Log2 of the divide ratio for a clock-select value (0 = stopped).
    function automatic int unsigned div_shift(input logic [2:0] s);
        case (s)
            3'd1:    return 1;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 7;
            3'd5:    return 9;
            3'd6:    return 11;
            3'd7:    return 12;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
// Clock prescaler: produces a one-cycle tick every 2^div_shift(sel)
// system clocks. Assumes PS_W is wide enough for the largest ratio.
// A select of zero holds the count at zero; restart clears it.
module rfsh_prescaler
    import rfsh_pkg::*;
#(
    parameter int PS_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       tick
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] lim;

    // Terminal count for the current select.
    always_comb begin
        lim  = PS_W'((32'd1 << div_shift(sel)) - 32'd1);
        tick = (sel != 3'd0) && (pcnt >= lim);
    end

    // Divider count: hold at zero when stopped, wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || sel == 3'd0 || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick); // R2
    AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0) |=> (pcnt == '0)); // R1

endmodule

// File: rtl/rfsh_counter.sv
// Refresh counter with compare: advances on each prescaler tick,
// clears and pulses req for one cycle when it equals the compare value.
// Software loads take priority over counting.
module rfsh_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_cnt,
    input  logic             ld_cmp,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic             req
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;

    // Counter advance, match clear and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            req <= 1'b0;
        end else begin
            req <= 1'b0;
            if (ld_cnt) begin
                cnt <= wdata;
            end else if (tick) begin
                if (cnt == cmp) begin
                    cnt <= '0;
                    req <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Compare register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '1;
        end else if (ld_cmp) begin
            cmp <= wdata;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_cnt) |=> $stable(cnt)); // R1
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (cnt == '0)); // R4
    AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(tick)); // R4

endmodule

// File: rtl/rfsh_seq_fsm.sv
// Command sequencer: on a request runs precharge-all, the precharge
// interval, optional waits, auto-refresh and three recovery NOPs.
// A request seen mid-train is held and served right after recovery.
// Assumes the interval fields stay steady while a train runs.
module rfsh_seq_fsm
    import rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] rp_cyc,
    input  logic [1:0] wt_cyc,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       pre_all,
    output logic       busy
);

    rfsh_state_e state;
    logic [1:0]  tmr;
    logic        pend;
    logic        go;
    logic        accept;

    // Start a train from idle or straight out of the last recovery cycle.
    always_comb begin
        go     = pend || req;
        accept = go && (state == ST_IDLE || state == ST_RC2);
    end

    // State walk, interval timer and held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
            pend  <= 1'b0;
        end else begin
            pend <= go && !accept;
            unique case (state)
                ST_IDLE: if (accept) state <= ST_PALL;
                ST_PALL: begin
                    state <= ST_RP;
                    tmr   <= rp_cyc;
                end
                ST_RP: begin
                    if (tmr != 2'd0) begin
                        tmr <= tmr - 2'd1;
                    end else if (wt_cyc == 2'd0) begin
                        state <= ST_REF;
                    end else begin
                        state <= ST_WAIT;
                        tmr   <= wt_cyc - 2'd1;
                    end
                end
                ST_WAIT: begin
                    if (tmr != 2'd0) tmr <= tmr - 2'd1;
                    else             state <= ST_REF;
                end
                ST_REF:  state <= ST_RR;
                ST_RR:   state <= ST_RC1;
                ST_RC1:  state <= ST_RC2;
                ST_RC2:  state <= accept ? ST_PALL : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin decode from the state register.
    always_comb begin
        ras_n   = !(state == ST_PALL || state == ST_REF);
        cas_n   = !(state == ST_REF);
        we_n    = !(state == ST_PALL);
        pre_all = (state == ST_PALL);
        busy    = (state != ST_IDLE);
    end

    AST_PALL_THEN_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PALL) |=> (state == ST_RP)); // R5
    AST_HELD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && state == ST_RC2) |=> (state == ST_PALL)); // R7
    AST_WAIT_NEEDS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wt_cyc != 2'd0)); // R6

endmodule

// File: rtl/sdram_refresh_seq.sv
// Top of the refresh sequencer: register write decode, prescaler,
// refresh counter and command sequencer. Clock enable is held high.
module sdram_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             sdr_cke,
    output logic             sdr_ras_n,
    output logic             sdr_cas_n,
    output logic             sdr_we_n,
    output logic             sdr_pre_all,
    output logic             ext_bus_busy
);

    logic [2:0] clk_sel_q;
    logic [1:0] rp_q;
    logic [1:0] wt_q;
    logic       sel_wr;
    logic       tick;
    logic       req;
    logic       nop_w;
    logic       pall_w;
    logic       ref_w;

    assign sel_wr = wr_en && (wr_addr == RA_CLKSEL);

    // Control field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_q <= 3'd0;
            rp_q      <= 2'd0;
            wt_q      <= 2'd0;
        end else if (wr_en) begin
            if (wr_addr == RA_CLKSEL) clk_sel_q <= wr_data[2:0];
            if (wr_addr == RA_PRECHG) rp_q      <= wr_data[1:0];
            if (wr_addr == RA_WAITS)  wt_q      <= wr_data[1:0];
        end
    end

    rfsh_prescaler #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (clk_sel_q),
        .restart (sel_wr),
        .tick    (tick)
    );

    rfsh_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_cnt (wr_en && wr_addr == RA_COUNT),
        .ld_cmp (wr_en && wr_addr == RA_COMPARE),
        .wdata  (wr_data),
        .tick   (tick),
        .req    (req)
    );

    rfsh_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .rp_cyc  (rp_q),
        .wt_cyc  (wt_q),
        .ras_n   (sdr_ras_n),
        .cas_n   (sdr_cas_n),
        .we_n    (sdr_we_n),
        .pre_all (sdr_pre_all),
        .busy    (ext_bus_busy)
    );

    assign sdr_cke = 1'b1;

    // Command classification used by the pin-level checks.
    always_comb begin
        nop_w  = sdr_ras_n && sdr_cas_n && sdr_we_n;
        pall_w = !sdr_ras_n && sdr_cas_n && !sdr_we_n;
        ref_w  = !sdr_ras_n && !sdr_cas_n && sdr_we_n;
    end

    AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_bus_busy |-> (nop_w && !sdr_pre_all)); // R8
    AST_PALL_SELECTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        pall_w |-> sdr_pre_all); // R5
    AST_REF_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_w |=> nop_w ##1 nop_w ##1 nop_w); // R6

endmodule

// File: tb/sim_sdram_refresh_seq.sv
// Scoreboard bench: the phase driver computes expected precharge-all
// cycles into a queue; the monitor pops and compares them at the pins.
module sim_sdram_refresh_seq;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = 3'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             cke, ras_n, cas_n, we_n, pre_all, busy;

    sdram_refresh_seq #(.CNT_W(CNT_W), .PS_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sdr_cke(cke), .sdr_ras_n(ras_n),
        .sdr_cas_n(cas_n), .sdr_we_n(we_n), .sdr_pre_all(pre_all),
        .ext_bus_busy(busy)
    );

    always #4 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    int    cur_rp = 0;
    int    cur_wt = 0;
    int    busy_end = 0;
    int    ref_exp = -1;
    int    n_pall = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R4";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Monitor: classify the pin command each cycle and compare.
    always @(negedge clk) begin
        if (mon_en) begin
            if (!ras_n && cas_n && !we_n) begin
                n_pall++;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected PALL"}, cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, {cur_tag, " PALL cycle"}, cyc, e);
                end
                check(pre_all == 1'b1, "R5 precharge-select during PALL", int'(pre_all), 1);
                ref_exp  = cyc + cur_rp + cur_wt + 2;
                busy_end = cyc + 6 + cur_rp + cur_wt;
            end else if (!ras_n && !cas_n && we_n) begin
                check(cyc == ref_exp, "R6 REF cycle", cyc, ref_exp);
            end else begin
                check(ras_n && cas_n && we_n && !pre_all, "R8 NOP outside commands",
                      {ras_n, cas_n, we_n, pre_all}, 4'b1110);
            end
            check(busy == (cyc < busy_end), "R8 busy window", int'(busy), int'(cyc < busy_end));
            check(cke == 1'b1, "R9 clock enable high", int'(cke), 1);
        end
    end

    // Driver: one register write, returning the cycle count of its edge.
    task automatic wr_reg(input logic [2:0] a, input int d, output int at);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CNT_W'(d);
        @(posedge clk);
        #1;
        at    = cyc;
        wr_en = 1'b0;
    endtask

    function automatic int ratio_of(input int s);
        case (s)
            1: return 2;
            2: return 8;
            3: return 32;
            4: return 128;
            5: return 512;
            6: return 2048;
            7: return 4096;
            default: return 0;
        endcase
    endfunction

    // One phase: program, start, predict PALL cycles, stop, drain, check.
    task automatic run_phase(input int v, input int c, input int s, input int rp,
                             input int wt, input int ncyc, input string tag);
        int at, wc, ratio, z, seqlen, lastp, p;
        cur_tag = tag;
        wr_reg(3'd3, rp, at);
        wr_reg(3'd4, wt, at);
        cur_rp = rp;
        cur_wt = wt;
        wr_reg(3'd0, v, at);
        wr_reg(3'd1, c, at);
        wr_reg(3'd2, s, wc);
        ratio  = ratio_of(s);
        z      = wc + ncyc;
        seqlen = 6 + rp + wt;
        lastp  = -1000;
        // R3 first match after c-v+1 ticks; R4 then every c+1; R7 hold and merge.
        for (int e = wc + ratio * (c - v + 1); e <= z; e += ratio * (c + 1)) begin
            if (e + 1 <= lastp) continue;
            p = (e + 1 > lastp + seqlen) ? e + 1 : lastp + seqlen;
            exp_q.push_back(p);
            lastp = p;
        end
        while (cyc < z - 1) begin
            @(posedge clk);
            #1;
        end
        wr_reg(3'd2, 0, at);
        repeat (40) @(posedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " all predicted PALLs seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        int at;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R8 idle pins and busy low, R9 clock enable high.
        check(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
        check(ras_n && cas_n && we_n && !pre_all, "R8 NOP after reset",
              {ras_n, cas_n, we_n, pre_all}, 4'b1110);
        check(cke == 1'b1, "R9 clock enable after reset", int'(cke), 1);
        mon_en = 1'b1;

        // R1: counter and compare at zero but select left at zero: no refresh.
        cur_tag = "R1";
        wr_reg(3'd0, 0, at);
        wr_reg(3'd1, 0, at);
        repeat (100) @(posedge clk);
        #1;
        check(n_pall == 0, "R1 no PALL while stopped", n_pall, 0);

        run_phase(0, 4, 1, 0, 0, 80,  "R4");
        run_phase(3, 9, 2, 2, 1, 300, "R3");
        run_phase(0, 5, 1, 3, 3, 100, "R6");
        run_phase(0, 3, 1, 1, 3, 100, "R7");
        for (int s = 1; s <= 7; s++) begin
            run_phase(0, 1, s, 0, 2, 6 * ratio_of(s), "R2");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule